// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is the master side of a three-wire serial EEPROM that holds 64 words of 16 bits. One start pulse, carrying a word count, makes it read that many consecutive words from address 0 upward. For each word it selects the part and shifts out a 9-bit read command. It then checks the dummy bit that a present and healthy part drives low, clocks in the 16 data bits and deselects the part with one trailing clock pulse.

Every received word comes out on a 16-bit bus with a one-cycle valid strobe. A one-cycle done pulse ends the run. If the dummy-bit check fails, the run stops at once and an error flag is raised and held. The serial clock's low (setup) and high intervals are each `HALF_CYC` system clock cycles long, so the serial rate follows from the system clock and that parameter.

Top module: `mw_eeprom_reader`

## Requirements
- R1: Each word access sends 9 command bits on `eep_di`, most significant first: a start bit of 1, the opcode bits 1 then 0, then the 6-bit word address, giving the value 0x180 OR address. The EEPROM takes each bit on the rising edge of `eep_sk`.
- R2: `eep_cs` is high during each of the 25 serial clock pulses of a completed word access (9 command, 16 data). `eep_cs` and `eep_di` change only while `eep_sk` is low. Each pulse consists of `HALF_CYC` cycles low followed by `HALF_CYC` cycles high.
- R3: The block samples `eep_do` as the 9th command pulse ends. If it reads 1, the run aborts: no further word is read, `eep_cs` and `eep_sk` return low, and `done` pulses with `error` high.
- R4: The 16 data bits are received most significant first. Each bit is sampled from `eep_do` in the cycle in which `eep_sk` falls. The assembled word appears on `word_data` with a one-cycle `word_valid` pulse.
- R5: After every completed word, `eep_cs` goes low and exactly one further `eep_sk` pulse is given before the next command.
- R6: Words are read at addresses 0, 1, 2 and so on, up to the effective count minus 1, in that order.
- R7: A start with `word_count` equal to 0 gives a `done` pulse with no serial clock pulse and no word.
- R8: A `word_count` above 64 is treated as 64.
- R9: A start pulse that arrives while a run is in progress is ignored. The run continues with its original count and ends with a single `done` pulse.
- R10: After reset, `eep_cs`, `eep_sk`, `eep_di`, `word_valid`, `done` and `error` are all 0.
- R11: `error` stays set after an aborted run until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| word_count | input | 7 | Number of words to read (0 to 64, larger values clamp to 64) |
| eep_do | input | 1 | Serial data from the EEPROM |
| eep_cs | output | 1 | EEPROM chip select, active high |
| eep_sk | output | 1 | Serial clock to the EEPROM |
| eep_di | output | 1 | Serial data to the EEPROM |
| word_valid | output | 1 | One-cycle strobe marking a received word |
| word_data | output | 16 | Received word |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Dummy-bit check failed in the last run |

## Verification
The hardest case to reach from the ports is an abort in the middle of a run. The dummy bit has to read 1 for one particular word, after earlier words have already finished cleanly. The bench's EEPROM model can be told which address should answer with a high dummy bit. The stimulus then asks for more words than that address, so the run must show the earlier words and their trailing pulses, a 9-pulse selection for the faulty word, and nothing after it. A second awkward case is a start pulse landing during a run. It is issued part way through a short run with a larger count, and the scoreboard confirms that only the original words arrive.

// File: rtl/mw_pkg.sv
package mw_pkg;

  localparam int MW_ADDR_W  = 6;
  localparam int MW_WORD_W  = 16;
  localparam int MW_CMD_W   = 3 + MW_ADDR_W;
  localparam int MW_CNT_W   = MW_ADDR_W + 1;
  localparam int MW_DEPTH   = 1 << MW_ADDR_W;
  localparam int MW_IDX_W   = $clog2(MW_WORD_W) + 1;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_CMD  = 2'd1,
    K_DATA = 2'd2,
    K_STOP = 2'd3
  } mw_kind_e;

  // Start bit, read opcode (1,0), then the word address.
  function automatic logic [MW_CMD_W-1:0] mw_read_cmd(input logic [MW_ADDR_W-1:0] a);
    return {3'b110, a};
  endfunction

  // Command bit sent in slot idx (slot 0 goes first, MSB first).
  function automatic logic mw_cmd_bit(input logic [MW_ADDR_W-1:0] a,
                                      input logic [MW_IDX_W-1:0] idx);
    logic [MW_CMD_W-1:0] c;
    c = mw_read_cmd(a);
    return c[MW_CMD_W - 1 - int'(idx)];
  endfunction

  // Requested count limited to the array depth.
  function automatic logic [MW_CNT_W-1:0] mw_clamp_count(input logic [MW_CNT_W-1:0] c);
    if (int'(c) > MW_DEPTH) return MW_CNT_W'(MW_DEPTH);
    return c;
  endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] next_q
);
  logic [WIDTH-1:0] q;

  assign next_q = {q[WIDTH-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= next_q;
    end
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MW_CNT_W-1:0] count_i,
  input  logic                tick,
  input  logic                din,
  output logic                cs,
  output logic                sk,
  output logic                di,
  output logic                shift_en,
  output logic                word_end,
  output logic                done,
  output logic                error,
  output logic                busy
);
  localparam logic [MW_IDX_W-1:0] CMD_LAST  = MW_IDX_W'(MW_CMD_W - 1);
  localparam logic [MW_IDX_W-1:0] DATA_LAST = MW_IDX_W'(MW_WORD_W - 1);

  mw_kind_e               kind;
  logic                   hi;
  logic [MW_IDX_W-1:0]    bit_idx;
  logic [MW_ADDR_W-1:0]   addr;
  logic [MW_ADDR_W-1:0]   last_addr;
  logic [MW_CNT_W-1:0]    eff_cnt;
  logic                   pulse_end;

  assign eff_cnt   = mw_clamp_count(count_i);
  assign busy      = (kind != K_IDLE);
  assign pulse_end = tick && hi;
  assign cs        = (kind == K_CMD) || (kind == K_DATA);
  assign sk        = hi;
  assign di        = (kind == K_CMD) && mw_cmd_bit(addr, bit_idx);
  assign shift_en  = pulse_end && (kind == K_DATA);
  assign word_end  = shift_en && (bit_idx == DATA_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= K_IDLE;
      hi        <= 1'b0;
      bit_idx   <= '0;
      addr      <= '0;
      last_addr <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (kind == K_IDLE) begin
        hi <= 1'b0;
        if (start) begin
          error <= 1'b0;
          if (eff_cnt == '0) begin
            done <= 1'b1;
          end else begin
            kind      <= K_CMD;
            bit_idx   <= '0;
            addr      <= '0;
            last_addr <= MW_ADDR_W'(eff_cnt - 1'b1);
          end
        end
      end else if (tick && !hi) begin
        hi <= 1'b1;
      end else if (pulse_end) begin
        hi <= 1'b0;
        unique case (kind)
          K_CMD: begin
            if (bit_idx == CMD_LAST) begin
              if (din) begin
                kind  <= K_IDLE;
                done  <= 1'b1;
                error <= 1'b1;
              end else begin
                kind    <= K_DATA;
                bit_idx <= '0;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
          K_DATA: begin
            if (bit_idx == DATA_LAST) begin
              kind <= K_STOP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
          K_STOP: begin
            if (addr == last_addr) begin
              kind <= K_IDLE;
              done <= 1'b1;
            end else begin
              kind    <= K_CMD;
              bit_idx <= '0;
              addr    <= addr + 1'b1;
            end
          end
          default: kind <= K_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int HALF_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [MW_CNT_W-1:0]  word_count,
  input  logic                 eep_do,
  output logic                 eep_cs,
  output logic                 eep_sk,
  output logic                 eep_di,
  output logic                 word_valid,
  output logic [MW_WORD_W-1:0] word_data,
  output logic                 done,
  output logic                 error
);
  logic                 tick;
  logic                 busy;
  logic                 shift_en;
  logic                 word_end;
  logic [MW_WORD_W-1:0] rx_next;

  mw_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  mw_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .count_i  (word_count),
    .tick     (tick),
    .din      (eep_do),
    .cs       (eep_cs),
    .sk       (eep_sk),
    .di       (eep_di),
    .shift_en (shift_en),
    .word_end (word_end),
    .done     (done),
    .error    (error),
    .busy     (busy)
  );

  mw_rx_shift #(.WIDTH(MW_WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (eep_do),
    .next_q   (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= word_end;
      if (word_end) word_data <= rx_next;
    end
  end
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic eep_cs,
  input logic eep_sk,
  input logic eep_di,
  input logic word_valid,
  input logic done,
  input logic error
);
  // R2
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eep_sk && $past(eep_sk)) |-> $stable(eep_di));

  // R2
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eep_sk && $past(eep_sk)) |-> $stable(eep_cs));

  // R2
  cs_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eep_cs) |-> !eep_sk);

  // R3
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eep_cs && !eep_sk));

  // R4
  valid_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && done));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(error) |-> $past(!busy));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .eep_cs     (eep_cs),
  .eep_sk     (eep_sk),
  .eep_di     (eep_di),
  .word_valid (word_valid),
  .done       (done),
  .error      (error)
);

// File: tb/test_mw_eeprom_reader.sv
module test_mw_eeprom_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  word_count = '0;
  logic        eep_do = 1'b1;
  logic        eep_cs, eep_sk, eep_di;
  logic        word_valid;
  logic [15:0] word_data;
  logic        done, error;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mw_eeprom_reader #(.HALF_CYC(3)) i_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .eep_do(eep_do), .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di),
    .word_valid(word_valid), .word_data(word_data), .done(done), .error(error)
  );

  function automatic logic [15:0] tb_word(input int a);
    return 16'((a * 1031) ^ 16'hC35A);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model and observers (sampled on falling system clock)
  int        fault_addr = -1;
  int        m_next_addr = 0;
  int        m_bits = 0;
  logic [8:0] m_cmd = '0;
  int        m_cur = 0;
  int        stop_pulses = 0;
  int        sk_rises = 0;
  int        done_seen = 0;
  logic      sk_q = 0, cs_q = 0;
  logic [15:0] exp_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (eep_sk && !sk_q) begin
        sk_rises++;
        if (!eep_cs) begin
          stop_pulses++;
        end else begin
          m_bits++;
          if (m_bits <= 9) begin
            m_cmd = {m_cmd[7:0], eep_di};
            if (m_bits == 9) begin
              // R1: command value 0x180 | address, addresses in order (R6)
              chk(m_cmd == (9'h180 | 9'(m_next_addr)), "R1", "command word",
                  int'(m_cmd), 'h180 | m_next_addr);
              m_cur = int'(m_cmd[5:0]);
              eep_do = (m_cur == fault_addr);
            end
          end else if (m_bits <= 25) begin
            eep_do = tb_word(m_cur)[25 - m_bits];
          end
        end
      end
      if (!eep_cs && cs_q) begin
        // R2: pulses per selection (9 on an aborted access)
        chk(m_bits == ((m_cur == fault_addr) ? 9 : 25), "R2", "pulses while selected",
            m_bits, (m_cur == fault_addr) ? 9 : 25);
        m_bits = 0;
        m_next_addr++;
        eep_do = 1'b1;
      end
      if (word_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected word", int'(word_data), 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(word_data == e, "R4", "word data", int'(word_data), int'(e));
        end
      end
      if (done) done_seen++;
      sk_q = eep_sk;
      cs_q = eep_cs;
    end
  end

  task automatic run_case(input int req_cnt, input int fault, input int exp_words,
                          input bit exp_err, input string req, input int extra_start_at);
    int waited;
    fault_addr = fault;
    m_next_addr = 0;
    stop_pulses = 0;
    sk_rises = 0;
    done_seen = 0;
    for (int i = 0; i < exp_words; i++) exp_q.push_back(tb_word(i));
    @(negedge clk);
    word_count = 7'(req_cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: cleared by the accepted start
    chk(error == 1'b0, "R11", "error after start", int'(error), 0);
    waited = 0;
    while (done_seen == 0 && waited < 30000) begin
      @(negedge clk);
      waited++;
      if (waited == extra_start_at) begin
        word_count = 7'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited++;
      end
    end
    repeat (20) @(negedge clk);
    chk(done_seen == 1, req, "done pulses", done_seen, 1);
    chk(exp_q.size() == 0, req, "words missing", exp_q.size(), 0);
    chk(error == exp_err, req, "error flag", int'(error), int'(exp_err));
    // R5: one trailing pulse per completed word
    chk(stop_pulses == exp_words, "R5", "trailing pulses", stop_pulses, exp_words);
    chk(!eep_cs && !eep_sk, req, "bus idle after run", {eep_cs, eep_sk}, 0);
    exp_q.delete();
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "WDOG", "watchdog expired", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({eep_cs, eep_sk, eep_di, word_valid, done, error} == 6'b0, "R10",
        "outputs in reset", {eep_cs, eep_sk, eep_di, word_valid, done, error}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({eep_cs, eep_sk, word_valid, done, error} == 5'b0, "R10",
        "outputs after reset", {eep_cs, eep_sk, word_valid, done, error}, 0);

    run_case(3, -1, 3, 0, "R6", 0);
    run_case(1, -1, 1, 0, "R4", 0);
    run_case(64, -1, 64, 0, "R6", 0);
    run_case(100, -1, 64, 0, "R8", 0);
    run_case(0, -1, 0, 0, "R7", 0);
    chk(sk_rises == 0, "R7", "clock pulses for zero count", sk_rises, 0);
    run_case(5, 2, 2, 1, "R3", 0);
    repeat (30) @(negedge clk);
    chk(error == 1'b1, "R11", "error held while idle", int'(error), 1);
    run_case(2, -1, 2, 0, "R9", 100);
    run_case(4, 0, 0, 1, "R3", 0);
    run_case(2, -1, 2, 0, "R11", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule